// File: doc/BRIEF.md
# Keyboard Scancode to Front-Panel Pin Translator

This block takes a byte stream of keyboard scancodes and turns it into eight active-low front-panel lines. Four lines model two rotary wheels, volume and navigation. Each wheel has a step line and a direction line. The other four lines model push buttons: favourites, menu, volume and navigation. A lone prefix byte marks the next code as an extended key. The four arrow keys arrive as extended codes and turn the wheels. Plain codes work the buttons.

The block keeps a set of the events that are currently held. A held button that is pressed again is ignored. A held wheel key that is pressed again produces a fresh pulse on its lines: the lines go high for one cycle and then low again. Codes arrive on a valid/ready stream. A code is taken on any cycle where `code_valid` and `code_ready` are both high. `code_ready` drops only during the one-cycle high phase of a wheel re-pulse. A sender that holds `code_valid` high during that cycle keeps its byte on `code_data`, and the byte is taken on the next cycle.

Top module: `scan_panel_xlate`

## Requirements
- R1: The byte 0xE0 changes no output and arms an extended flag. The flag is consumed by the next accepted code, whatever that code is.
- R2: In every other code, bit 7 set means a release and bit 7 clear means a press. Bits 6:0 select the key.
- R3: After the prefix, key 0x48 (up) selects panel bits 2 and 3, 0x50 (down) selects bit 2, 0x4B (left) selects bits 0 and 1, and 0x4D (right) selects bit 0.
- R4: Without the prefix, key 0x21 selects bit 4 (favourites), 0x32 selects bit 5 (menu), 0x0F selects bit 6 (volume button) and 0x1C selects bit 7 (navigation button).
- R5: Any other key, including a button key after the prefix or an arrow key without it, leaves the outputs and the held set unchanged.
- R6: A press whose bits are not held drives those bits low and adds them to the held set. A release drives its bits high and removes them from the held set.
- R7: A plain (non-extended) press whose bits overlap the held set is ignored.
- R8: An extended press whose bits overlap the held set drives those bits high for exactly one cycle, then drives them low again.
- R9: `code_ready` is low only during that one high cycle and is high at all other times out of reset.
- R10: Reset drives all outputs high, empties the held set, clears the extended flag and raises `code_ready`.
- R11: Outputs change only on the clock edge that accepts a code, or on the edge that ends a re-pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| code_valid | input | 1 | Scancode byte present |
| code_ready | output | 1 | Block can take a byte this cycle |
| code_data | input | 8 | Scancode byte |
| panel_n | output | 8 | Active-low panel lines: 0 vol step, 1 vol dir, 2 nav step, 3 nav dir, 4 favourites, 5 menu, 6 vol button, 7 nav button |

## Verification
The bound checker watches several rules on every cycle:
- When a code is accepted, the panel lines agree with the held set.
- A release drives its bits high, and a prefix byte or a suppressed button repeat leaves the lines untouched.
- A stall on `code_ready` lasts one cycle, the bits being re-pulsed read high during that stall, and those bits read low right after it.
- Between accepted codes the lines do not move.

Some behaviour shows only in the bench's scenarios:
- The key-to-bit mapping itself.
- The prefix being consumed by an unmapped code.
- Overlap between a held left wheel key and a right wheel repeat.
- Reset clearing the prefix and the held set in the middle of a sequence.

// File: rtl/scan_panel_pkg.sv
package scan_panel_pkg;

  // Panel bit positions (the neighbouring logic decodes these)
  localparam int EV_VOL_STEP = 0;
  localparam int EV_VOL_DIR  = 1;
  localparam int EV_NAV_STEP = 2;
  localparam int EV_NAV_DIR  = 3;
  localparam int EV_FAV      = 4;
  localparam int EV_MENU     = 5;
  localparam int EV_VOL_BTN  = 6;
  localparam int EV_NAV_BTN  = 7;

  // Key numbers (low seven bits of a code)
  localparam int KEY_UP    = 'h48;
  localparam int KEY_DOWN  = 'h50;
  localparam int KEY_LEFT  = 'h4B;
  localparam int KEY_RIGHT = 'h4D;
  localparam int KEY_FAV   = 'h21;
  localparam int KEY_MENU  = 'h32;
  localparam int KEY_VOLB  = 'h0F;
  localparam int KEY_NAVB  = 'h1C;
  localparam int KEY_PREFIX = 'hE0;

  typedef enum logic [1:0] {
    ACT_NONE    = 2'd0,
    ACT_PRESS   = 2'd1,
    ACT_RELEASE = 2'd2,
    ACT_PULSE   = 2'd3
  } panel_act_e;

endpackage

// File: rtl/scan_decode.sv
module scan_decode
  import scan_panel_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int EVT_W  = 8
) (
  input  logic [CODE_W-1:0] code,
  input  logic              ext_armed,
  output logic              is_prefix,
  output logic              is_release,
  output logic [EVT_W-1:0]  evt_mask
);
  localparam int KEY_W = CODE_W - 1;

  logic [KEY_W-1:0] key;

  always_comb begin
    key        = code[KEY_W-1:0];
    is_release = code[CODE_W-1];
    is_prefix  = (code == CODE_W'(KEY_PREFIX));
    evt_mask   = '0;
    if (ext_armed) begin
      if (key == KEY_W'(KEY_UP)) begin
        evt_mask[EV_NAV_STEP] = 1'b1;
        evt_mask[EV_NAV_DIR]  = 1'b1;
      end else if (key == KEY_W'(KEY_DOWN)) begin
        evt_mask[EV_NAV_STEP] = 1'b1;
      end else if (key == KEY_W'(KEY_LEFT)) begin
        evt_mask[EV_VOL_STEP] = 1'b1;
        evt_mask[EV_VOL_DIR]  = 1'b1;
      end else if (key == KEY_W'(KEY_RIGHT)) begin
        evt_mask[EV_VOL_STEP] = 1'b1;
      end
    end else begin
      if (key == KEY_W'(KEY_FAV))       evt_mask[EV_FAV]     = 1'b1;
      else if (key == KEY_W'(KEY_MENU)) evt_mask[EV_MENU]    = 1'b1;
      else if (key == KEY_W'(KEY_VOLB)) evt_mask[EV_VOL_BTN] = 1'b1;
      else if (key == KEY_W'(KEY_NAVB)) evt_mask[EV_NAV_BTN] = 1'b1;
    end
  end
endmodule

// File: rtl/scan_policy.sv
module scan_policy
  import scan_panel_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             accept,
  input  logic             is_prefix,
  input  logic             is_release,
  input  logic             ext_armed,
  input  logic [EVT_W-1:0] evt_mask,
  input  logic [EVT_W-1:0] held_mask,
  output panel_act_e       act
);
  logic overlap;

  always_comb begin
    overlap = |(held_mask & evt_mask);
    act     = ACT_NONE;
    if (accept && !is_prefix && (evt_mask != '0)) begin
      if (is_release)     act = ACT_RELEASE;
      else if (!overlap)  act = ACT_PRESS;
      else if (ext_armed) act = ACT_PULSE;   // wheel repeat: re-pulse
      else                act = ACT_NONE;    // button repeat: suppressed
    end
  end
endmodule

// File: rtl/panel_bit.sv
module panel_bit
  import scan_panel_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel,
  input  panel_act_e act,
  input  logic       pulse_end,
  output logic       pin_n,
  output logic       held
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_n <= 1'b1;
      held  <= 1'b0;
    end else if (pulse_end) begin
      pin_n <= 1'b0;
    end else if (sel) begin
      unique case (act)
        ACT_PRESS:   begin pin_n <= 1'b0; held <= 1'b1; end
        ACT_RELEASE: begin pin_n <= 1'b1; held <= 1'b0; end
        ACT_PULSE:   begin pin_n <= 1'b1; held <= 1'b1; end
        default:     ;
      endcase
    end
  end
endmodule

// File: rtl/scan_panel_xlate.sv
module scan_panel_xlate
  import scan_panel_pkg::*;
#(
  parameter int CODE_W = 8,
  parameter int EVT_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              code_valid,
  output logic              code_ready,
  input  logic [CODE_W-1:0] code_data,
  output logic [EVT_W-1:0]  panel_n
);
  logic             ext_q;
  logic             pend_q;
  logic [EVT_W-1:0] pulse_mask_q;
  logic             accept;
  logic             dec_prefix;
  logic             dec_rel;
  logic [EVT_W-1:0] dec_mask;
  logic [EVT_W-1:0] held_mask;
  panel_act_e       act;

  assign code_ready = !pend_q;
  assign accept     = code_valid && code_ready;

  scan_decode #(.CODE_W(CODE_W), .EVT_W(EVT_W)) u_dec (
    .code       (code_data),
    .ext_armed  (ext_q),
    .is_prefix  (dec_prefix),
    .is_release (dec_rel),
    .evt_mask   (dec_mask)
  );

  scan_policy #(.EVT_W(EVT_W)) u_pol (
    .accept     (accept),
    .is_prefix  (dec_prefix),
    .is_release (dec_rel),
    .ext_armed  (ext_q),
    .evt_mask   (dec_mask),
    .held_mask  (held_mask),
    .act        (act)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ext_q        <= 1'b0;
      pend_q       <= 1'b0;
      pulse_mask_q <= '0;
    end else begin
      if (accept) ext_q <= dec_prefix;
      pend_q       <= (act == ACT_PULSE);
      pulse_mask_q <= (act == ACT_PULSE) ? dec_mask : '0;
    end
  end

  for (genvar i = 0; i < EVT_W; i++) begin : g_pin
    panel_bit u_bit (
      .clk       (clk),
      .rst_n     (rst_n),
      .sel       (dec_mask[i]),
      .act       (act),
      .pulse_end (pend_q && pulse_mask_q[i]),
      .pin_n     (panel_n[i]),
      .held      (held_mask[i])
    );
  end
endmodule

// File: rtl/scan_panel_chk.sv
module scan_panel_chk #(
  parameter int CODE_W = 8,
  parameter int EVT_W  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              code_valid,
  input logic              code_ready,
  input logic [CODE_W-1:0] code_data,
  input logic [EVT_W-1:0]  panel_n,
  input logic              ext_q,
  input logic              dec_rel,
  input logic [EVT_W-1:0]  dec_mask,
  input logic [EVT_W-1:0]  held_mask,
  input logic [EVT_W-1:0]  pulse_mask_q
);
  logic acc;
  assign acc = code_valid && code_ready;

  AST_PREFIX_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    acc && (code_data == CODE_W'('hE0)) |=> $stable(panel_n)); // R1

  AST_RELEASE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    acc && dec_rel && (dec_mask != '0) |=>
      ((panel_n & $past(dec_mask)) == $past(dec_mask))); // R6

  AST_PINS_MATCH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready |-> (panel_n == ~held_mask)); // R6

  AST_BUTTON_REPEAT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !ext_q && !dec_rel && ((held_mask & dec_mask) != '0) |=> $stable(panel_n)); // R7

  AST_PULSE_HIGH_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ready |-> ((panel_n & pulse_mask_q) == pulse_mask_q) && (pulse_mask_q != '0)); // R8

  AST_PULSE_ENDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ready |=> ((panel_n & $past(pulse_mask_q)) == '0)); // R8

  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    !code_ready |=> code_ready); // R9

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    code_ready && !code_valid |=> $stable(panel_n)); // R11
endmodule

bind scan_panel_xlate scan_panel_chk #(.CODE_W(CODE_W), .EVT_W(EVT_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .code_valid   (code_valid),
  .code_ready   (code_ready),
  .code_data    (code_data),
  .panel_n      (panel_n),
  .ext_q        (ext_q),
  .dec_rel      (dec_rel),
  .dec_mask     (dec_mask),
  .held_mask    (held_mask),
  .pulse_mask_q (pulse_mask_q)
);

// File: tb/sim_scan_panel_xlate.sv
module sim_scan_panel_xlate;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       code_valid = 1'b0;
  logic       code_ready;
  logic [7:0] code_data = 8'h00;
  logic [7:0] panel_n;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  scan_panel_xlate u0 (
    .clk        (clk),
    .rst_n      (rst_n),
    .code_valid (code_valid),
    .code_ready (code_ready),
    .code_data  (code_data),
    .panel_n    (panel_n)
  );

  // {req, code, panel after accept edge, panel one cycle later}
  localparam int NV = 32;
  localparam logic [31:0] VEC [NV] = '{
    {8'd4,  8'h21, 8'hEF, 8'hEF},  // R4 R6 favourites press
    {8'd7,  8'h21, 8'hEF, 8'hEF},  // R7 button repeat ignored
    {8'd2,  8'hA1, 8'hFF, 8'hFF},  // R2 release
    {8'd6,  8'hA1, 8'hFF, 8'hFF},  // R6 release of unheld key
    {8'd4,  8'h0F, 8'hBF, 8'hBF},  // R4 volume button
    {8'd4,  8'h1C, 8'h3F, 8'h3F},  // R4 navigation button
    {8'd4,  8'h32, 8'h1F, 8'h1F},  // R4 menu
    {8'd6,  8'h8F, 8'h5F, 8'h5F},  // R6 release volume button
    {8'd1,  8'hE0, 8'h5F, 8'h5F},  // R1 prefix silent
    {8'd3,  8'h48, 8'h53, 8'h53},  // R3 up
    {8'd1,  8'hE0, 8'h53, 8'h53},  // R1
    {8'd8,  8'h48, 8'h5F, 8'h53},  // R8 up repeat re-pulse
    {8'd5,  8'h48, 8'h53, 8'h53},  // R5 arrow without prefix
    {8'd1,  8'hE0, 8'h53, 8'h53},  // R1
    {8'd6,  8'hC8, 8'h5F, 8'h5F},  // R6 release up
    {8'd1,  8'hE0, 8'h5F, 8'h5F},  // R1
    {8'd3,  8'h4B, 8'h5C, 8'h5C},  // R3 left
    {8'd1,  8'hE0, 8'h5C, 8'h5C},  // R1
    {8'd8,  8'h4D, 8'h5D, 8'h5C},  // R8 right overlaps held left
    {8'd1,  8'hE0, 8'h5C, 8'h5C},  // R1
    {8'd6,  8'hCB, 8'h5F, 8'h5F},  // R6 release left
    {8'd1,  8'hE0, 8'h5F, 8'h5F},  // R1
    {8'd3,  8'h50, 8'h5B, 8'h5B},  // R3 down
    {8'd1,  8'hE0, 8'h5B, 8'h5B},  // R1
    {8'd5,  8'h21, 8'h5B, 8'h5B},  // R5 button after prefix
    {8'd1,  8'h21, 8'h4B, 8'h4B},  // R1 flag consumed, button works
    {8'd5,  8'h55, 8'h4B, 8'h4B},  // R5 unmapped
    {8'd1,  8'hE0, 8'h4B, 8'h4B},  // R1
    {8'd6,  8'hD0, 8'h4F, 8'h4F},  // R6 release down
    {8'd6,  8'hA1, 8'h5F, 8'h5F},  // R6
    {8'd6,  8'h9C, 8'hDF, 8'hDF},  // R6
    {8'd6,  8'hB2, 8'hFF, 8'hFF}   // R6 all released
  };

  task automatic check(input int req, input logic [7:0] got, input logic [7:0] exp,
                       input string what);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL R%0d %s: got %02h expected %02h", req, what, got, exp);
    end
  endtask

  // Drive at the falling edge; returns at the falling edge after the accept edge.
  task automatic send(input logic [7:0] code);
    @(negedge clk);
    code_valid = 1'b1;
    code_data  = code;
    while (!code_ready) @(negedge clk);
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check(10, panel_n, 8'hFF, "reset panel");
    check(10, {7'd0, code_ready}, 8'h01, "reset ready");
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [7:0] req, cd, ea, ef;
      {req, cd, ea, ef} = VEC[i];
      send(cd);
      check(int'(req), panel_n, ea, $sformatf("vec %0d after", i));
      // R9: ready low exactly when a re-pulse is in its high phase
      check(9, {7'd0, code_ready}, {7'd0, (ea == ef)}, $sformatf("vec %0d ready", i));
      @(negedge clk);
      check(int'(req), panel_n, ef, $sformatf("vec %0d final", i));
      check(11, {7'd0, code_ready}, 8'h01, $sformatf("vec %0d ready back", i));
    end

    // R9 back-pressure: a byte held during the stall is taken one cycle later
    send(8'hE0); send(8'h50);               // nav step low: FB
    @(negedge clk);
    code_valid = 1'b1; code_data = 8'hE0;   // accepted at next edge
    @(negedge clk);
    code_data = 8'h50;                      // repeat -> stall after this edge
    @(negedge clk);
    code_data = 8'h32;                      // menu waits during stall
    check(9, {7'd0, code_ready}, 8'h00, "stall cycle");
    check(8, panel_n, 8'hFF, "pulse high phase");
    @(negedge clk);
    check(9, {7'd0, code_ready}, 8'h01, "stall ended");
    check(8, panel_n, 8'hFB, "pulse back low");
    @(negedge clk);
    code_valid = 1'b0;
    check(9, panel_n, 8'hDB, "held byte taken after stall");
    send(8'hB2); send(8'hE0); send(8'hD0);
    check(6, panel_n, 8'hFF, "cleanup");

    // R10 reset mid-sequence clears held set and prefix
    send(8'h21);
    send(8'hE0);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(10, panel_n, 8'hFF, "reset clears pins");
    rst_n = 1'b1;
    @(negedge clk);
    send(8'h48);
    check(10, panel_n, 8'hFF, "prefix cleared by reset");
    send(8'h21);
    check(10, panel_n, 8'hEF, "held set cleared by reset");
    @(negedge clk);
    check(11, panel_n, 8'hEF, "idle stable");

    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule